// File: doc/BRIEF.md
# Keyboard Controller Output Pin Driver

This block turns one general-purpose output bit of a keyboard controller into the data and enable signals for a pad. A mode input chooses between two behaviours. In quasi-bidirectional mode the pin is pulled low whenever the bit is 0. A change of the bit from 0 to 1 gets a short burst of strong high drive, so that the pin rises quickly. After that burst the block lets go of the pin, and an external weak pull-up holds it high. In open-drain mode the block only ever pulls the pin low, and a bit value of 1 releases the pad. The pin can then share a wire with other open-drain signals, such as a system management interrupt line.

The port bit and the mode are registered on each clock. A rising bit that is seen at a clock edge loads a down-counter with the burst length. The pad enable stays asserted while that counter is non-zero. A mode change clears the counter at the same edge. The pad data output always follows the registered bit.

Top module: `kbd_port_pin`

## Requirements
- R1: When the registered port bit is 0, pin_out is 0 and pin_oe is 1 in both modes, starting one clock after port_bit is sampled low.
- R2: In quasi-bidirectional mode (od_mode = 0), a port_bit that was 0 and is sampled 1 at a clock edge gives pin_out = 1 with pin_oe = 1 from that edge onward.
- R3: The strong high drive lasts exactly STRONG_CLKS clocks. After that, pin_out stays 1 and pin_oe is 0, and the pin is held only by the pull-up.
- R4: In open-drain mode (od_mode = 1), a port bit of 1 gives pin_oe = 0. The block never shows pin_oe = 1 together with pin_out = 1 in this mode.
- R5: A new 0-to-1 change of the bit reloads the full burst, even when a burst is still running. A bit that stays at 1 never starts another burst.
- R6: During and straight after reset, pin_out is 1 and pin_oe is 0, with no burst.
- R7: A change of od_mode takes effect at the next clock and cancels any burst that is running. A rising bit sampled at the same edge as a mode change starts no burst.
- R8: The burst length is the parameter STRONG_CLKS, default 4. The counter width is derived from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_bit | input | 1 | Port data bit from the controller |
| od_mode | input | 1 | 1 = open-drain, 0 = quasi-bidirectional |
| pin_out | output | 1 | Data value to the pad |
| pin_oe | output | 1 | Pad output enable |

## Verification
The assertions assume that port_bit and od_mode are stable around the rising clock edge and that reset is held for at least one edge. They also assume that the only source of a burst is a rising bit seen while the registered and the new mode are both quasi-bidirectional. The bench changes its inputs only on the falling edge, so every input is settled well before the sampling edge. Its random stimulus flips the mode rarely and keeps the bit at 1 often enough for bursts to run to the end. Directed sequences then place a rising bit inside a burst and at the same edge as a mode change.

// File: rtl/kbp_pkg.sv
package kbp_pkg;

  typedef enum logic {
    PIN_QUASI      = 1'b0,
    PIN_OPEN_DRAIN = 1'b1
  } pin_mode_e;

  // Next value of the strong-drive counter; cancel has priority over restart.
  function automatic int unsigned burst_next(input int unsigned cur,
                                             input int unsigned load,
                                             input logic restart,
                                             input logic cancel);
    if (cancel)       return 0;
    else if (restart) return load;
    else if (cur > 0) return cur - 1;
    else              return 0;
  endfunction

  // Pad enable rule: low drive always, high drive only during a quasi burst.
  function automatic logic pad_enable(input logic bit_val,
                                      input logic burst_on,
                                      input pin_mode_e mode);
    return !bit_val || (burst_on && (mode == PIN_QUASI));
  endfunction

endpackage

// File: rtl/kbp_edge_track.sv
module kbp_edge_track
  import kbp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      port_bit,
  input  logic      od_mode,
  output logic      bit_q,
  output pin_mode_e mode_q,
  output logic      rise_evt,
  output logic      mode_flip_evt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_q  <= 1'b1;
      mode_q <= PIN_QUASI;
    end else begin
      bit_q  <= port_bit;
      mode_q <= pin_mode_e'(od_mode);
    end
  end

  assign rise_evt      = port_bit && !bit_q;
  assign mode_flip_evt = (od_mode != logic'(mode_q));

  // R6: the registered bit comes out of reset high
  assert_reset_high_R6: assert property (@(posedge clk)
    !rst_n |=> bit_q);

endmodule

// File: rtl/kbp_drive_timer.sv
module kbp_drive_timer
  import kbp_pkg::*;
#(
  parameter int unsigned STRONG_CLKS = 4,
  localparam int unsigned CW = $clog2(STRONG_CLKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          cancel,
  output logic [CW-1:0] count_q,
  output logic          strong_en
);

  localparam logic [CW-1:0] LOAD_VAL = CW'(STRONG_CLKS);

  logic [CW-1:0] count_d;

  always_comb begin
    count_d = CW'(burst_next(int'(count_q), int'(LOAD_VAL), restart, cancel));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign strong_en = (count_q != '0);

  // R8: the counter never goes above the configured burst length
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= LOAD_VAL);

  // R3: a running burst counts down by one per clock when left alone
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strong_en && !restart && !cancel) |=> (count_q == $past(count_q) - CW'(1)));

  // R5: a restart loads the full length
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !cancel) |=> (count_q == LOAD_VAL));

endmodule

// File: rtl/kbp_pad_mux.sv
module kbp_pad_mux
  import kbp_pkg::*;
(
  input  logic      bit_q,
  input  logic      strong_en,
  input  pin_mode_e mode_q,
  output logic      pin_out,
  output logic      pin_oe
);

  assign pin_out = bit_q;
  assign pin_oe  = pad_enable(bit_q, strong_en, mode_q);

  // R1: a low pad value is always driven
  assert_low_driven_R1: assert final (bit_q || pin_oe);

endmodule

// File: rtl/kbd_port_pin.sv
module kbd_port_pin
  import kbp_pkg::*;
#(
  parameter int unsigned STRONG_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_bit,
  input  logic od_mode,
  output logic pin_out,
  output logic pin_oe
);

  localparam int unsigned CW = $clog2(STRONG_CLKS + 1);

  logic          bit_q;
  pin_mode_e     mode_q;
  logic          rise_evt;
  logic          mode_flip_evt;
  logic          burst_restart;
  logic [CW-1:0] burst_count;
  logic          strong_en;

  kbp_edge_track u_track (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_bit      (port_bit),
    .od_mode       (od_mode),
    .bit_q         (bit_q),
    .mode_q        (mode_q),
    .rise_evt      (rise_evt),
    .mode_flip_evt (mode_flip_evt)
  );

  assign burst_restart = rise_evt && (mode_q == PIN_QUASI);

  kbp_drive_timer #(.STRONG_CLKS(STRONG_CLKS)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (burst_restart),
    .cancel    (mode_flip_evt),
    .count_q   (burst_count),
    .strong_en (strong_en)
  );

  kbp_pad_mux u_mux (
    .bit_q     (bit_q),
    .strong_en (strong_en),
    .mode_q    (mode_q),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // R1: a low port bit is driven low on the next clock
  assert_low_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !port_bit |=> (pin_oe && !pin_out));

  // R2: a rising bit in steady quasi mode drives high at once
  assert_rise_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_bit && !pin_out && !od_mode && mode_q == PIN_QUASI) |=> (pin_oe && pin_out));

  // R4: open-drain mode never drives high
  assert_od_no_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    od_mode |=> !(pin_oe && pin_out));

  // R5: a bit held at 1 with no burst does not start one
  assert_no_retrigger_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (port_bit && pin_out && !strong_en) |=> !strong_en);

  // R7: a mode change cancels the burst
  assert_mode_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_flip_evt |=> !strong_en);

  // R6: reset leaves the pin released
  assert_reset_release_R6: assert property (@(posedge clk)
    !rst_n |=> (pin_out && !pin_oe));

endmodule

// File: tb/kbd_port_pin_test.sv
module kbd_port_pin_test;

  localparam int unsigned N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_bit = 1'b1;
  logic od_mode = 1'b0;
  logic pin_out, pin_oe;

  int checks = 0;
  int fails  = 0;

  // reference state, advanced once per rising edge
  logic m_bit  = 1'b1;
  logic m_mode = 1'b0;
  int   m_rem  = 0;

  always #2.5 clk = ~clk;

  kbd_port_pin #(.STRONG_CLKS(N)) uut (
    .clk(clk), .rst_n(rst_n), .port_bit(port_bit), .od_mode(od_mode),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int ref_rem(input logic old_bit, input logic old_mode,
                                 input int rem, input logic nb, input logic nm);
    if (nm != old_mode) return 0;
    if (!old_bit && nb && !nm) return int'(N);
    return (rem > 0) ? rem - 1 : 0;
  endfunction

  function automatic logic ref_oe(input logic b, input logic md, input int rem);
    if (!b) return 1'b1;
    if (md) return 1'b0;
    return rem > 0;
  endfunction

  task automatic check(input string tag, input logic got_o, input logic got_e,
                       input logic exp_o, input logic exp_e);
    checks++;
    if (got_o !== exp_o || got_e !== exp_e) begin
      fails++;
      $display("FAIL %s: out/oe actual %b/%b expected %b/%b at %0t",
               tag, got_o, got_e, exp_o, exp_e, $time);
    end
  endtask

  task automatic compare_model(input string force_tag);
    string tag;
    if (force_tag != "")  tag = force_tag;
    else if (!m_bit)      tag = "R1";
    else if (m_mode)      tag = "R4";
    else if (m_rem > 0)   tag = "R2";
    else                  tag = "R3";
    check(tag, pin_out, pin_oe, m_bit, ref_oe(m_bit, m_mode, m_rem));
  endtask

  // compare outputs of the last edge, then apply inputs for the next edge
  task automatic cyc(input logic b, input logic m, input string tag);
    @(negedge clk);
    compare_model(tag);
    port_bit = b;
    od_mode  = m;
    m_rem  = ref_rem(m_bit, m_mode, m_rem, b, m);
    m_bit  = b;
    m_mode = m;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int plen;
    logic rb, rm;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R6", pin_out, pin_oe, 1'b1, 1'b0);
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, "R6");

    // R8 / R2 / R3: measure a full burst in quasi mode
    cyc(1'b0, 1'b0, "");
    cyc(1'b1, 1'b0, "R1");
    plen = 0;
    for (int i = 0; i < int'(N) + 3; i++) begin
      @(negedge clk);
      if (pin_oe && pin_out) plen++;
    end
    checks++;
    if (plen != int'(N)) begin
      fails++;
      $display("FAIL R8: burst length actual %0d expected %0d", plen, N);
    end
    m_rem = 0;
    cyc(1'b1, 1'b0, "R3");
    cyc(1'b1, 1'b0, "R5");

    // R5: restart in the middle of a burst
    cyc(1'b0, 1'b0, "");
    cyc(1'b1, 1'b0, "R1");
    cyc(1'b1, 1'b0, "R2");
    cyc(1'b0, 1'b0, "R2");
    cyc(1'b1, 1'b0, "R1");
    for (int i = 0; i < int'(N) + 1; i++) cyc(1'b1, 1'b0, "R5");

    // R7: a mode flip during a burst cancels it
    cyc(1'b0, 1'b0, "");
    cyc(1'b1, 1'b0, "R1");
    cyc(1'b1, 1'b1, "R2");
    cyc(1'b1, 1'b0, "R7");
    cyc(1'b1, 1'b0, "R7");

    // R7: a rise together with a mode change starts no burst
    cyc(1'b0, 1'b1, "");
    cyc(1'b1, 1'b0, "R1");
    cyc(1'b1, 1'b0, "R7");

    // R4: open-drain releases on 1 and drives on 0
    cyc(1'b0, 1'b1, "");
    cyc(1'b1, 1'b1, "R1");
    cyc(1'b1, 1'b1, "R4");
    cyc(1'b0, 1'b1, "R4");
    cyc(1'b1, 1'b1, "R1");
    cyc(1'b1, 1'b0, "R4");

    // random traffic
    rm = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      rb = ($urandom % 4) != 0;
      if (($urandom % 16) == 0) rm = ~rm;
      cyc(rb, rm, "");
    end
    cyc(1'b1, rm, "");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule